// File: doc/BRIEF.md
# Parallel-Path Summing Sinc Decimator

This block is the digital back end of a multi-path single-bit modulator. On every rising clock edge it takes a word of `N_PATHS` single-bit path decisions at once. It reduces that word to a count of the high bits. This count acts as a one-clock path filter: it lowers the effective rate of `N_PATHS` samples per clock to one sample per clock, and it behaves like a sample-and-hold at the clock rate. The count then passes through two moving-sum (sinc) stages of length `SINC_LEN`. The first stage runs at the clock rate. The second stage integrates at the clock rate and differences once every `SINC_LEN` clocks. Together they give a decimated word and a one-clock strobe. For the defaults (8 paths, length 8) the overall oversampling ratio is 64 and the result is a 9-bit word.

A mode input selects an undecimated output instead. In that mode the output of the first moving-sum stage is delivered on every clock, limited to 6 bits. Both stages run all the time, so the mode can change on any clock without a reset.

After reset, the strobe stays low until every sample inside the output's window was captured after the reset. This start-up gap equals the latency of the filter chain.

Top module: `path_sinc_decim`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is 0, starting at once (asynchronous).
- R2: The sample taken at each edge is the number of high bits in path_i (0 to 8). Only that number matters, not which bits are high. A constant input with four high bits gives a decimated result of 256.
- R3: Edges are numbered from 1, starting with the first rising edge after reset is released. Let c(n) be the count sampled at edge n, with c(n)=0 for n<1. With bypass_i=0 at edge e, valid_o is 1 after edge e only when e is a multiple of 8. Then data_o = sum for j=2..9 and i=1..8 of c(e-j-i).
- R4: The decimated result saturates, so the full-scale value 512 is output as 511.
- R5: With bypass_i=0, valid_o stays 0 up to edge 23. With bypass_i=1, valid_o stays 0 up to edge 9.
- R6: With bypass_i=1 at edge e and e>=10, valid_o is 1 after edge e. data_o = min(sum for i=2..9 of c(e-i), 63), and bits 8..6 are zero.
- R7: bypass_i is sampled at every edge. Switching mode needs no reset, gives correct data on the next strobe, and does not shift the multiple-of-8 decimation cadence.
- R8: data_o changes only on edges where valid_o is set. Between strobes it holds the last strobed value (0 after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one edge per set of path bits |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bypass_i | input | 1 | 1 selects the undecimated output, 0 the decimated output |
| path_i | input | N_PATHS | Parallel single-bit path decisions |
| data_o | output | OUT_W | Filtered result |
| valid_o | output | 1 | One-clock strobe marking a new data_o |

## Verification
On every cycle, the assertions check the following. The path count never goes above the number of paths. The moving-sum window never wraps out of range. A decimated strobe falls only on phase zero and only after the full fill time. An undecimated result never goes past 6 bits. The output holds between strobes. The bench scenarios are needed to show the rest against the window-sum reference: that the values are correct, that the arrangement of bits does not matter, that full scale saturates at 511, that mid-stream mode switches work, and that a second reset restarts the fill period.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {
    MODE_DECIM  = 1'b0,
    MODE_BYPASS = 1'b1
  } mode_e;
endpackage

// File: rtl/psd_path_count.sv
module psd_path_count #(
  parameter int N_PATHS = 8,
  parameter int CNT_W   = $clog2(N_PATHS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PATHS-1:0] path_i,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [CNT_W-1:0] sum;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_PATHS; i++) sum = sum + CNT_W'(path_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= sum;
  end

  assign cnt_o = cnt_q;

  assert_count_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_PATHS));
endmodule

// File: rtl/psd_sinc_full.sv
module psd_sinc_full #(
  parameter int IN_W     = 4,
  parameter int IN_MAX   = 8,
  parameter int SINC_LEN = 8,
  parameter int SUM_W    = $clog2(SINC_LEN * IN_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  in_i,
  output logic [SUM_W-1:0] sum_o
);
  // integrator wraps modulo 2^SUM_W; comb difference stays exact
  logic [SUM_W-1:0]                acc_q;
  logic [SINC_LEN-1:0][SUM_W-1:0]  dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      dly_q <= '0;
    end else begin
      acc_q <= acc_q + SUM_W'(in_i);
      dly_q <= {dly_q[SINC_LEN-2:0], acc_q};
    end
  end

  assign sum_o = acc_q - dly_q[SINC_LEN-1];

  assert_window_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o <= SUM_W'(SINC_LEN * IN_MAX));
endmodule

// File: rtl/psd_sinc_decim.sv
module psd_sinc_decim
  import psd_pkg::*;
#(
  parameter int IN_W     = 7,
  parameter int IN_MAX   = 64,
  parameter int SINC_LEN = 8,
  parameter int OUT_W    = 9,
  parameter int BYP_W    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  logic [IN_W-1:0]  win_i,
  output logic [OUT_W-1:0] data_o,
  output logic             valid_o
);
  localparam int ACC_W    = $clog2(SINC_LEN * IN_MAX + 1);
  localparam int PH_W     = $clog2(SINC_LEN);
  localparam int RUN_MAX  = 3 * SINC_LEN - 1;  // first decimated window fully post-reset
  localparam int RUN_W    = $clog2(RUN_MAX + 1);
  localparam int BYP_FILL = SINC_LEN + 1;
  localparam int OUT_MAX  = (1 << OUT_W) - 1;
  localparam int BYP_MAX  = (1 << BYP_W) - 1;

  mode_e            mode;
  logic [ACC_W-1:0] acc_q, last_q, diff;
  logic [PH_W-1:0]  ph_q;
  logic [RUN_W-1:0] run_q;
  logic [OUT_W-1:0] data_q;
  logic             valid_q;
  logic             ph_end;

  assign mode   = mode_e'(bypass_i);
  assign diff   = acc_q - last_q;
  assign ph_end = (ph_q == PH_W'(SINC_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      last_q  <= '0;
      ph_q    <= '0;
      run_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      acc_q   <= acc_q + ACC_W'(win_i);
      ph_q    <= ph_end ? '0 : ph_q + 1'b1;
      if (run_q != RUN_W'(RUN_MAX)) run_q <= run_q + 1'b1;
      if (ph_end) last_q <= acc_q;  // comb runs in both modes
      valid_q <= 1'b0;
      if (mode == MODE_BYPASS) begin
        if (run_q >= RUN_W'(BYP_FILL)) begin
          valid_q <= 1'b1;
          data_q  <= (win_i > IN_W'(BYP_MAX)) ? OUT_W'(BYP_MAX) : OUT_W'(win_i);
        end
      end else if (ph_end && run_q == RUN_W'(RUN_MAX)) begin
        valid_q <= 1'b1;
        data_q  <= (diff > ACC_W'(OUT_MAX)) ? OUT_W'(OUT_MAX) : diff[OUT_W-1:0];
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  assert_decim_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(bypass_i)) |-> (ph_q == '0));
  assert_decim_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(bypass_i)) |-> ($past(run_q) == RUN_W'(RUN_MAX)));
  assert_any_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (run_q > RUN_W'(BYP_FILL)));
  assert_bypass_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(bypass_i)) |-> (data_o <= OUT_W'(BYP_MAX)));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

// File: rtl/path_sinc_decim.sv
module path_sinc_decim #(
  parameter int N_PATHS  = 8,
  parameter int SINC_LEN = 8,
  parameter int OUT_W    = $clog2(SINC_LEN * SINC_LEN * N_PATHS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bypass_i,
  input  logic [N_PATHS-1:0] path_i,
  output logic [OUT_W-1:0]   data_o,
  output logic               valid_o
);
  localparam int CNT_W   = $clog2(N_PATHS + 1);
  localparam int WIN_MAX = SINC_LEN * N_PATHS;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam int BYP_W   = $clog2(WIN_MAX);

  logic [CNT_W-1:0] cnt;
  logic [WIN_W-1:0] win;

  psd_path_count #(
    .N_PATHS(N_PATHS),
    .CNT_W  (CNT_W)
  ) u_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .path_i(path_i),
    .cnt_o (cnt)
  );

  psd_sinc_full #(
    .IN_W    (CNT_W),
    .IN_MAX  (N_PATHS),
    .SINC_LEN(SINC_LEN),
    .SUM_W   (WIN_W)
  ) u_sinc_full (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (cnt),
    .sum_o (win)
  );

  psd_sinc_decim #(
    .IN_W    (WIN_W),
    .IN_MAX  (WIN_MAX),
    .SINC_LEN(SINC_LEN),
    .OUT_W   (OUT_W),
    .BYP_W   (BYP_W)
  ) u_sinc_decim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bypass_i(bypass_i),
    .win_i   (win),
    .data_o  (data_o),
    .valid_o (valid_o)
  );
endmodule

// File: tb/path_sinc_decim_bench.sv
module path_sinc_decim_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int K = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bypass_i = 1'b0;
  logic [K-1:0] path_i = '0;
  logic [8:0] data_o;
  logic       valid_o;

  int n_tests = 0;
  int n_fail  = 0;
  int e = 0;
  int last_exp = 0;
  int hist [0:8191];
  bit modeh [0:8191];
  string tag_ovr = "";

  always #2.5 clk = ~clk;

  path_sinc_decim u_path_sinc_decim (
    .clk_i(clk), .rst_ni(rst_ni), .bypass_i(bypass_i),
    .path_i(path_i), .data_o(data_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (edge %0d)", tag, what, act, exp, e);
    end
  endtask

  function automatic int c(input int u);
    return (u < 1) ? 0 : hist[u];
  endfunction

  task automatic compare();
    bit byp = modeh[e];
    int ev, ed, raw;
    string t;
    raw = 0;
    if (byp) begin
      ev = (e >= 10) ? 1 : 0;
      for (int i = 2; i <= 9; i++) raw += c(e - i);
      ed = (raw > 63) ? 63 : raw;
    end else begin
      ev = (e % 8 == 0 && e >= 24) ? 1 : 0;
      for (int j = 2; j <= 9; j++)
        for (int i = 1; i <= 8; i++) raw += c(e - j - i);
      ed = (raw > 511) ? 511 : raw;
    end
    if (tag_ovr != "") t = tag_ovr;
    else if (e < 24) t = "R5";
    else t = byp ? "R6" : "R3";
    chk(valid_o == ev[0], t, int'(valid_o), ev, "valid_o");
    if (ev != 0) begin
      chk(int'(data_o) == ed, (raw != ed) ? (byp ? "R6" : "R4") : t, int'(data_o), ed, "data_o");
      last_exp = ed;
    end else begin
      chk(int'(data_o) == last_exp, "R8", int'(data_o), last_exp, "held data_o");
    end
  endtask

  task automatic step(input logic [K-1:0] p, input logic byp);
    path_i = p;
    bypass_i = byp;
    @(posedge clk);
    e++;
    hist[e] = $countones(p);
    modeh[e] = byp;
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(valid_o == 1'b0, "R1", int'(valid_o), 0, "valid_o in reset");
    chk(data_o == '0, "R1", int'(data_o), 0, "data_o in reset");
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && data_o == '0, "R1", int'(data_o), 0, "held in reset");
    rst_ni = 1'b1;
    e = 0;
    last_exp = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired at edge %0d", e);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    do_reset();
    // zeros, then constant count 4 in three arrangements
    repeat (40) step(8'h00, 1'b0);
    repeat (40) step(8'h0F, 1'b0);
    chk(int'(data_o) == 256, "R2", int'(data_o), 256, "count 4 low nibble");
    repeat (40) step(8'hF0, 1'b0);
    chk(int'(data_o) == 256, "R2", int'(data_o), 256, "count 4 high nibble");
    repeat (40) step(8'h55, 1'b0);
    chk(int'(data_o) == 256, "R2", int'(data_o), 256, "count 4 alternating");
    // full scale saturation
    repeat (40) step(8'hFF, 1'b0);
    chk(int'(data_o) == 511, "R4", int'(data_o), 511, "full scale");
    // ramp of counts 0..8
    for (int k = 0; k < 216; k++) step(8'((9'(1) << (k % 9)) - 9'd1), 1'b0);
    // random
    for (int k = 0; k < 600; k++) step(8'($urandom), 1'b0);
    // bypass mode
    do_reset();
    repeat (5) step(8'h00, 1'b1);
    repeat (20) step(8'hFF, 1'b1);
    chk(int'(data_o) == 63, "R6", int'(data_o), 63, "bypass full scale");
    repeat (20) step(8'h03, 1'b1);
    chk(int'(data_o) == 16, "R6", int'(data_o), 16, "bypass count 2");
    for (int k = 0; k < 200; k++) step(8'($urandom), 1'b1);
    // mode switches mid-stream
    tag_ovr = "R7";
    for (int k = 0; k < 300; k++) step(8'($urandom), ((k / 13) % 2) == 1);
    tag_ovr = "";
    // reset mid-run restarts the fill period
    do_reset();
    for (int k = 0; k < 60; k++) step(8'($urandom), 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule